// File: doc/BRIEF.md
# Fixed-Reference Two-Bit Response Checker

The block gives a go/no-go verdict on the response of a single-output circuit under test. The test sequence is ordered outside the block so that a fault-free circuit answers with a run of zeros followed by a run of ones, each run at least one bit long. Because the expected counts of rising steps, falling steps and transitions in such a response are the small constants 0 and 1, the checker never needs a reference value that depends on the number of tests. Each count is kept in a saturating tracker that holds 0, 1 or "2 or more".

A response is opened by `clr`, streamed in one bit per `resp_valid` strobe and closed by `seq_end`. On the edge that accepts `seq_end` the block latches `pair_sel` and moves to its done state, where `pass` shows whether the chosen pair of counts met its constants. An additional mode checks a strictly alternating response 0101... by counting non-transitions with a leading 1 prefixed.

The control state machine has three states. IDLE (after reset or `clr`, no bit seen) goes to RUN on the first accepted bit and to DONE when `seq_end` is accepted. RUN (at least one bit seen) goes to DONE when `seq_end` is accepted. DONE holds until `clr`; `clr` returns every state to IDLE.

Top module: `fixed_ref_checker`

## Requirements
- R1: After reset or a cycle with `clr` high, `done` and `pass` are 0 and every tracker is empty, so the next response is judged without any trace of the previous one.
- R2: `done` is 0 while a response is streaming, becomes 1 on the clock edge that samples `seq_end` high, and stays 1 until `clr`.
- R3: `pass` is never 1 while `done` is 0.
- R4: For `pair_sel` codes 0 (rising=1, falling=0), 1 (transition=1, rising=1), 2 (transition=1, falling=0), 3 (transition=1, transitions with a 0 prefixed=1) and 4 (rising=1, transitions with a 0 prefixed=1), `pass` is 1 exactly when the response is p zeros then q ones with p ≥ 1 and q ≥ 1.
- R5: An empty response, a response of only zeros and a response of only ones all give `pass` = 0 in every mode.
- R6: For `pair_sel` code 5, `pass` is 1 exactly when the response has at least one bit, its first bit is 0 and every bit differs from the one before it.
- R7: `pair_sel` codes 6 and 7 always give `pass` = 0.
- R8: In DONE, `resp_valid`, `resp_bit`, `seq_end` and `pair_sel` have no effect; `done` and `pass` stay unchanged until `clr`.
- R9: The mode used is the value of `pair_sel` on the cycle `seq_end` is accepted; its value while bits stream is irrelevant.
- R10: A bit strobed on the same cycle as `seq_end` is part of the response.
- R11: `clr` takes priority over `resp_valid` and `seq_end` on the same cycle: the block goes to IDLE and that bit and end strobe are discarded.
- R12: Counts saturate and never wrap: a response with many steps of either direction never passes modes 0 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous start of a new response |
| resp_valid | input | 1 | Strobe: `resp_bit` carries a response bit |
| resp_bit | input | 1 | Response bit from the circuit under test |
| seq_end | input | 1 | Closes the response |
| pair_sel | input | 3 | Count pair selection, codes 0 to 7 |
| done | output | 1 | Response closed, verdict valid |
| pass | output | 1 | Verdict: response met the constants |

## Verification
The assertions take for granted only that `clr`, `seq_end` and `resp_valid` are sampled as clean levels on the rising edge; they place no limit on when strobes arrive, so the bench drives noise on all inputs in DONE and mixes `clr` with end strobes. The stimulus changes inputs only on the falling edge, opens each response with `clr`, and draws shapes from a fixed seed (well-formed zero-then-one runs, flipped copies, alternating patterns, random bits) with idle gaps between strobes, keeping responses short enough that saturation, not wrap, is what decides long ones.

// File: rtl/frc_pkg.sv
package frc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } frc_state_e;

    // event / tracker slots
    localparam int EV_RISE  = 0;
    localparam int EV_FALL  = 1;
    localparam int EV_TRANS = 2;
    localparam int EV_PTR0  = 3;  // transitions with 0 prefixed
    localparam int EV_SAME1 = 4;  // non-transitions with 1 prefixed
    localparam int NUM_EV   = 5;

    // pair_sel codes
    localparam logic [2:0] MODE_RISE_FALL  = 3'd0;
    localparam logic [2:0] MODE_TRANS_RISE = 3'd1;
    localparam logic [2:0] MODE_TRANS_FALL = 3'd2;
    localparam logic [2:0] MODE_TRANS_PTR  = 3'd3;
    localparam logic [2:0] MODE_RISE_PTR   = 3'd4;
    localparam logic [2:0] MODE_ALTERNATE  = 3'd5;

endpackage

// File: rtl/frc_sat_track.sv
module frc_sat_track #(
    parameter int SAT_MAX = 2,
    localparam int W = $clog2(SAT_MAX + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = W'(SAT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && (cnt != TOP)) begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/frc_event_gen.sv
module frc_event_gen
    import frc_pkg::*;
(
    input  logic              bit_in,
    input  logic              prev_bit,
    input  logic              first,
    output logic [NUM_EV-1:0] ev
);
    logic step_up;
    logic step_dn;

    always_comb begin
        step_up       = !first && !prev_bit && bit_in;
        step_dn       = !first && prev_bit && !bit_in;
        ev            = '0;
        ev[EV_RISE]   = step_up;
        ev[EV_FALL]   = step_dn;
        ev[EV_TRANS]  = step_up || step_dn;
        // virtual leading 0: the first bit is a step if it is 1
        ev[EV_PTR0]   = first ? bit_in : (prev_bit != bit_in);
        // virtual leading 1: the first bit is a repeat if it is 1
        ev[EV_SAME1]  = first ? bit_in : (prev_bit == bit_in);
    end
endmodule

// File: rtl/frc_verdict.sv
module frc_verdict
    import frc_pkg::*;
#(
    parameter int W = 2
) (
    input  logic [NUM_EV-1:0][W-1:0] cnt,
    input  logic [2:0]               mode,
    input  logic                     got_bit,
    output logic                     ok
);
    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = W'(1);

    logic rise_one;
    logic fall_zero;
    logic trans_one;
    logic ptr_one;
    logic same_zero;

    always_comb begin
        rise_one  = (cnt[EV_RISE]  == ONE);
        fall_zero = (cnt[EV_FALL]  == ZERO);
        trans_one = (cnt[EV_TRANS] == ONE);
        ptr_one   = (cnt[EV_PTR0]  == ONE);
        same_zero = (cnt[EV_SAME1] == ZERO);
        unique case (mode)
            MODE_RISE_FALL:  ok = rise_one  && fall_zero;
            MODE_TRANS_RISE: ok = trans_one && rise_one;
            MODE_TRANS_FALL: ok = trans_one && fall_zero;
            MODE_TRANS_PTR:  ok = trans_one && ptr_one;
            MODE_RISE_PTR:   ok = rise_one  && ptr_one;
            MODE_ALTERNATE:  ok = same_zero && got_bit;
            default:         ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/fixed_ref_checker.sv
module fixed_ref_checker
    import frc_pkg::*;
#(
    parameter int SAT_MAX = 2,
    parameter int SEL_W   = 3,
    localparam int CW     = $clog2(SAT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             resp_valid,
    input  logic             resp_bit,
    input  logic             seq_end,
    input  logic [SEL_W-1:0] pair_sel,
    output logic             done,
    output logic             pass
);
    frc_state_e state_q;
    frc_state_e state_d;

    logic                     accept;
    logic                     end_acc;
    logic                     prev_q;
    logic                     got_q;
    logic [2:0]               mode_q;
    logic [NUM_EV-1:0]        ev;
    logic [NUM_EV-1:0][CW-1:0] cnt;
    logic                     ok;

    assign accept  = resp_valid && !clr && (state_q != ST_DONE);
    assign end_acc = seq_end    && !clr && (state_q != ST_DONE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (end_acc)     state_d = ST_DONE;
                else if (accept) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (end_acc)     state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_DONE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (clr) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // response context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            got_q  <= 1'b0;
            mode_q <= '0;
        end else if (clr) begin
            prev_q <= 1'b0;
            got_q  <= 1'b0;
            mode_q <= '0;
        end else begin
            if (accept)  prev_q <= resp_bit;
            if (accept)  got_q  <= 1'b1;
            if (end_acc) mode_q <= pair_sel[2:0];
        end
    end

    frc_event_gen u_evg (
        .bit_in   (resp_bit),
        .prev_bit (prev_q),
        .first    (state_q == ST_IDLE),
        .ev       (ev)
    );

    for (genvar g = 0; g < NUM_EV; g++) begin : g_trk
        frc_sat_track #(.SAT_MAX(SAT_MAX)) u_trk (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .inc   (accept && ev[g]),
            .cnt   (cnt[g])
        );
    end

    frc_verdict #(.W(CW)) u_vrd (
        .cnt     (cnt),
        .mode    (mode_q),
        .got_bit (got_q),
        .ok      (ok)
    );

    // outputs
    always_comb begin
        done = 1'b0;
        pass = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN:  ;
            ST_DONE: begin
                done = 1'b1;
                pass = ok;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/frc_checker.sv
module frc_checker (
    input logic clk,
    input logic rst_n,
    input logic clr,
    input logic seq_end,
    input logic done,
    input logic pass
);
    AST_PASS_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> done);  // R3

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!done && !pass));  // R1

    AST_END_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_end && !clr) |=> done);  // R2

    AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> done);  // R2

    AST_VERDICT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> $stable(pass));  // R8
endmodule

bind fixed_ref_checker frc_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .seq_end (seq_end),
    .done    (done),
    .pass    (pass)
);

// File: tb/fixed_ref_checker_tb.sv
module fixed_ref_checker_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       resp_valid = 1'b0;
    logic       resp_bit = 1'b0;
    logic       seq_end = 1'b0;
    logic [2:0] pair_sel = 3'd0;
    logic       done;
    logic       pass;

    int n_chk = 0;
    int n_bad = 0;
    logic bits [0:127];
    int   blen = 0;

    always #4 clk = ~clk;

    fixed_ref_checker u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .resp_valid(resp_valid),
        .resp_bit(resp_bit), .seq_end(seq_end), .pair_sel(pair_sel),
        .done(done), .pass(pass)
    );

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    // zeros then ones, both runs nonempty (R4)
    function automatic bit ref_step();
        int k;
        if (blen < 2 || bits[0] != 1'b0) return 1'b0;
        k = 0;
        while (k < blen && bits[k] == 1'b0) k++;
        if (k == blen) return 1'b0;
        for (int i = k; i < blen; i++) if (bits[i] != 1'b1) return 1'b0;
        return 1'b1;
    endfunction

    // 0101... from a leading 0 (R6)
    function automatic bit ref_alt();
        if (blen < 1) return 1'b0;
        for (int i = 0; i < blen; i++) if (bits[i] != 1'(i % 2)) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit ref_pass(input int mode);
        if (mode <= 4) return ref_step();
        if (mode == 5) return ref_alt();
        return 1'b0;  // R7
    endfunction

    task automatic do_clr();
        @(negedge clk);
        clr = 1'b1; resp_valid = 1'b0; seq_end = 1'b0;
        @(negedge clk);
        clr = 1'b0;
    endtask

    // stream bits[0:blen-1], close, check; then drive noise in DONE
    task automatic run_seq(input int mode, input bit end_on_last, input string tag);
        bit exp;
        exp = ref_pass(mode);
        do_clr();
        for (int i = 0; i < blen; i++) begin
            @(negedge clk);
            if (i == blen / 2) chk(done, 1'b0, "R2", {tag, " done while streaming"});
            resp_valid = 1'b1;
            resp_bit   = bits[i];
            pair_sel   = 3'($urandom);  // R9: ignored until seq_end
            if (end_on_last && i == blen - 1) begin
                seq_end  = 1'b1;        // R10: last bit with end
                pair_sel = 3'(mode);
            end
            if ($urandom % 4 == 0 && !(end_on_last && i == blen - 1)) begin
                @(negedge clk);
                resp_valid = 1'b0;
                resp_bit   = 1'($urandom);
            end
        end
        if (!(end_on_last && blen > 0)) begin
            @(negedge clk);
            resp_valid = 1'b0;
            seq_end    = 1'b1;
            pair_sel   = 3'(mode);
        end
        @(negedge clk);
        seq_end = 1'b0; resp_valid = 1'b0;
        pair_sel = 3'($urandom);
        chk(done, 1'b1, "R2", {tag, " done after end"});
        chk(pass, exp, (mode <= 4) ? "R4" : ((mode == 5) ? "R6" : "R7"), {tag, " verdict"});
        // R8: inputs ignored in DONE
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            resp_valid = 1'($urandom); resp_bit = 1'($urandom);
            seq_end = 1'($urandom); pair_sel = 3'($urandom);
        end
        @(negedge clk);
        resp_valid = 1'b0; seq_end = 1'b0;
        chk(done, 1'b1, "R8", {tag, " done held"});
        chk(pass, exp, "R8", {tag, " verdict held"});
    endtask

    task automatic load_step(input int p, input int q);
        blen = p + q;
        for (int i = 0; i < blen; i++) bits[i] = (i >= p);
    endtask

    task automatic load_alt(input int n);
        blen = n;
        for (int i = 0; i < n; i++) bits[i] = 1'(i % 2);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got hang expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20417));
        repeat (3) @(negedge clk);
        chk(done, 1'b0, "R1", "done in reset");
        chk(pass, 1'b0, "R1", "pass in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(done, 1'b0, "R1", "done after reset");

        // directed corners
        for (int m = 0; m < 5; m++) begin
            load_step(1, 1); run_seq(m, 1'b0, "R4 01");
        end
        load_step(3, 0); run_seq(0, 1'b0, "R5 zeros");
        load_step(0, 4); run_seq(2, 1'b1, "R5 ones");
        blen = 0;        run_seq(5, 1'b0, "R5 empty");
        blen = 0;        run_seq(1, 1'b0, "R5 empty m1");
        load_alt(1);     run_seq(5, 1'b1, "R6 single 0");
        load_step(0, 1); run_seq(5, 1'b0, "R6 single 1");
        load_alt(9);     run_seq(5, 1'b1, "R6 odd alt");
        load_step(2, 3); run_seq(6, 1'b0, "R7 code6");
        load_step(2, 3); run_seq(7, 1'b1, "R7 code7");
        load_alt(12);    run_seq(0, 1'b0, "R12 many steps");
        load_alt(12);    run_seq(3, 1'b0, "R12 many steps ptr");

        // R11: clr with bit and end on the same cycle, then R1 fresh run
        do_clr();
        @(negedge clk); resp_valid = 1'b1; resp_bit = 1'b1;
        @(negedge clk); clr = 1'b1; seq_end = 1'b1; resp_bit = 1'b0;
        @(negedge clk); clr = 1'b0; seq_end = 1'b0; resp_valid = 1'b0;
        chk(done, 1'b0, "R11", "end discarded under clr");
        chk(pass, 1'b0, "R11", "pass under clr");
        @(negedge clk); resp_valid = 1'b1; resp_bit = 1'b0;
        @(negedge clk); resp_bit = 1'b1; seq_end = 1'b1; pair_sel = 3'd0;
        @(negedge clk); resp_valid = 1'b0; seq_end = 1'b0;
        chk(done, 1'b1, "R1", "fresh run done");
        chk(pass, 1'b1, "R1", "fresh run not tainted");

        // constrained random
        for (int r = 0; r < 400; r++) begin
            int kind;
            int mode;
            kind = $urandom % 5;
            mode = $urandom % 8;
            case (kind)
                0: load_step(1 + $urandom % 20, 1 + $urandom % 20);
                1: begin
                    blen = 1 + $urandom % 30;
                    for (int i = 0; i < blen; i++) bits[i] = 1'($urandom);
                end
                2: load_alt(1 + $urandom % 30);
                3: begin
                    load_step(1 + $urandom % 15, 1 + $urandom % 15);
                    bits[$urandom % blen] ^= 1'b1;
                end
                default: begin
                    load_alt(2 + $urandom % 20);
                    bits[$urandom % blen] ^= 1'b1;
                end
            endcase
            if (kind == 2 && mode < 5 && ($urandom % 2 == 0)) mode = 5;
            run_seq(mode, 1'($urandom), "rnd");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule